// File: doc/BRIEF.md
# Coarse-State Inclusive Probe Filter

This block sits at a home node and keeps a small directory cache of the blocks whose home is this node and that some core currently holds. Each incoming coherence read (shared) or write (ownership) request is looked up by address, and the filter answers with a routing decision. The decision is to serve the request from memory, to forward it to one recorded core, or to broadcast it to every core. The state kept per entry is deliberately coarse. It tells "one holder" from "more than one holder" and does not record which cores make up a group of holders.

A miss means no core holds the block. The filter then allocates an entry, and if the set has no free way it evicts one. Because the directory is inclusive, an evicted entry forces a recall: every copy of the victim block must be invalidated. The recall goes to all cores when the victim had many holders, and to the single recorded core otherwise. Caches never report clean evictions, so an entry leaves the directory only through a recall. Storage is organised as groups of four 4-way sets, which matches one wide storage line per group. While a recall is outstanding, requests that would touch the recalling set are held off until every acknowledgment has arrived.

Top module: `probe_filter`

## Requirements
- R1: After reset no response or recall is valid, `req_ready` is high, and every entry is invalid, so the first request to any address misses.
- R2: A request whose address matches no valid entry in its set (set = low log2(4*LINES) address bits, tag = the remaining bits) is answered one cycle after acceptance with route 0 (memory) and allocates an entry. A read installs the one-holder shared state and a write installs the one-holder exclusive state, and in both cases the requester is recorded as the holder.
- R3: A read that hits a one-holder entry (shared or exclusive) is answered with route 1 (forward) and `rsp_core` equal to the recorded holder, and the entry becomes many-holder.
- R4: A request that hits a many-holder entry is answered with route 2 (broadcast). A read leaves the entry many-holder, and route 3 is never produced.
- R5: A write hit is routed as in R3/R4 according to the prior state, and afterwards the entry is one-holder exclusive with the requester as holder.
- R6: On allocation the lowest-numbered invalid way is used. When all four ways are valid, the victim is the way named by a per-set round-robin pointer, which starts at way 0 and advances by one on each eviction.
- R7: An eviction produces, in the same cycle as the memory response, a recall pulse that carries the victim address {victim tag, set}. `recall_all` is 1 if the victim was many-holder; otherwise it is 0 and `recall_core` names the recorded holder. No recall is produced without an eviction.
- R8: After a recall, `req_ready` is low for any request to the recalling set until `recall_ack` has been pulsed 2**CORE_W times (broadcast recall) or once (single recall). It is also low for any request that would need another eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request can be accepted this cycle |
| req_getm | input | 1 | 1 = ownership (write) request, 0 = shared read |
| req_addr | input | ADDR_W | block address |
| req_core | input | CORE_W | requesting core |
| rsp_valid | output | 1 | routing decision valid (one cycle) |
| rsp_route | output | 2 | 0 memory, 1 forward, 2 broadcast |
| rsp_core | output | CORE_W | forward target (meaningful for route 1) |
| recall_valid | output | 1 | recall issued (one cycle) |
| recall_addr | output | ADDR_W | block to invalidate everywhere |
| recall_all | output | 1 | recall must reach all cores |
| recall_core | output | CORE_W | recall target when recall_all is 0 |
| recall_ack | input | 1 | one recall acknowledgment |

## Verification
The bench builds the filter with ADDR_W=8, CORE_W=2 and LINES=1. That gives four sets of four ways, four cores and six-bit tags. A generated stream of several hundred requests uses six tags per set, so every set fills, overflows and wraps its round-robin pointer many times. The same stream covers every state transition from every holder state, and broadcast and single recalls both occur. With four cores, the broadcast acknowledgment count stays short enough that the stall on the recalling set can be probed before every acknowledgment.

// File: rtl/probe_filter.sv
module probe_filter #(
  parameter int ADDR_W = 8,
  parameter int CORE_W = 2,
  parameter int LINES  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_getm,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  output logic              rsp_valid,
  output logic [1:0]        rsp_route,
  output logic [CORE_W-1:0] rsp_core,
  output logic              recall_valid,
  output logic [ADDR_W-1:0] recall_addr,
  output logic              recall_all,
  output logic [CORE_W-1:0] recall_core,
  input  logic              recall_ack
);
  localparam int NSETS  = LINES * 4;
  localparam int SET_W  = $clog2(NSETS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int N      = NSETS * 4;
  localparam int IDX_W  = SET_W + 2;
  localparam int NCORES = 1 << CORE_W;
  localparam logic [1:0] S_INV = 2'd0, S_EX = 2'd1, S_SH = 2'd2, S_MANY = 2'd3;
  localparam logic [1:0] RT_MEM = 2'd0, RT_FWD = 2'd1, RT_ALL = 2'd2;

  logic [TAG_W-1:0]  tag_q [N];
  logic [1:0]        st_q  [N];
  logic [CORE_W-1:0] own_q [N];
  logic [1:0]        rr_q  [NSETS];
  logic              busy_q;
  logic [SET_W-1:0]  rset_q;
  logic [CORE_W:0]   acks_q;

  wire [SET_W-1:0] set = req_addr[SET_W-1:0];
  wire [TAG_W-1:0] tg  = req_addr[ADDR_W-1:SET_W];

  logic [3:0] hitv, invv;
  logic [1:0] hway, fway;
  logic       hit, free;

  always_comb begin
    hit = 1'b0; free = 1'b0; hway = 2'd0; fway = 2'd0;
    for (int w = 3; w >= 0; w--) begin
      hitv[w] = (st_q[{set, 2'(w)}] != S_INV) && (tag_q[{set, 2'(w)}] == tg);
      invv[w] = (st_q[{set, 2'(w)}] == S_INV);
      if (hitv[w]) begin hit = 1'b1; hway = 2'(w); end
      if (invv[w]) begin free = 1'b1; fway = 2'(w); end
    end
  end

  wire [IDX_W-1:0] hidx = {set, hway};
  wire [IDX_W-1:0] vidx = {set, free ? fway : rr_q[set]};
  wire need_recall = !hit && !free;
  assign req_ready = !busy_q || (set != rset_q && !need_recall);
  wire acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        st_q[i] <= S_INV; tag_q[i] <= '0; own_q[i] <= '0;
      end
      for (int s = 0; s < NSETS; s++) rr_q[s] <= 2'd0;
      busy_q <= 1'b0; rset_q <= '0; acks_q <= '0;
      rsp_valid <= 1'b0; rsp_route <= RT_MEM; rsp_core <= '0;
      recall_valid <= 1'b0; recall_addr <= '0; recall_all <= 1'b0; recall_core <= '0;
    end else begin
      rsp_valid    <= acc;
      recall_valid <= 1'b0;
      if (busy_q && recall_ack) begin
        acks_q <= acks_q - 1'b1;
        if (acks_q == 1) busy_q <= 1'b0;
      end
      if (acc) begin
        if (hit) begin
          rsp_route <= (st_q[hidx] == S_MANY) ? RT_ALL : RT_FWD;
          rsp_core  <= own_q[hidx];
          if (req_getm) begin
            st_q[hidx]  <= S_EX;
            own_q[hidx] <= req_core;
          end else begin
            st_q[hidx]  <= S_MANY;
          end
        end else begin
          rsp_route   <= RT_MEM;
          rsp_core    <= req_core;
          tag_q[vidx] <= tg;
          st_q[vidx]  <= req_getm ? S_EX : S_SH;
          own_q[vidx] <= req_core;
          if (need_recall) begin
            recall_valid <= 1'b1;
            recall_addr  <= {tag_q[vidx], set};
            recall_all   <= (st_q[vidx] == S_MANY);
            recall_core  <= own_q[vidx];
            rr_q[set]    <= rr_q[set] + 2'd1;
            busy_q       <= 1'b1;
            rset_q       <= set;
            acks_q       <= (st_q[vidx] == S_MANY) ? (CORE_W+1)'(NCORES) : (CORE_W+1)'(1);
          end
        end
      end
    end
  end

  // R2: allocation only on a miss keeps tags unique within a set
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hitv));
  // R4: the reserved route code never appears
  p_route_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_route != 2'd3);
  // R7: a recall always accompanies a memory-routed response
  p_recall_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recall_valid |-> (rsp_valid && rsp_route == RT_MEM && busy_q));
  // R8: the set stays blocked until an acknowledgment releases it
  p_release_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(recall_ack));
  // R8: a blocked set starts only with a recall
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> recall_valid);
endmodule

// File: tb/probe_filter_tb.sv
module probe_filter_tb_top;
  localparam int AW = 8, CW = 2, NC = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_getm = 0, recall_ack = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_core = '0;
  logic req_ready, rsp_valid, recall_valid, recall_all;
  logic [1:0] rsp_route;
  logic [CW-1:0] rsp_core, recall_core;
  logic [AW-1:0] recall_addr;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  probe_filter #(.ADDR_W(AW), .CORE_W(CW), .LINES(1)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_getm, .req_addr, .req_core,
    .rsp_valid, .rsp_route, .rsp_core, .recall_valid, .recall_addr,
    .recall_all, .recall_core, .recall_ack);

  // model of the directory, written from the requirements
  logic [5:0] mtag [16];
  logic [1:0] mst [16];
  logic [1:0] mown [16];
  logic [1:0] mrr [4];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_req(input bit getm, input logic [5:0] tg, input logic [1:0] s, input logic [1:0] core);
    int hw = -1, fw = -1, v, ex_route, ex_core, nack;
    bit rec = 0, rall = 0;
    logic [1:0] rcore = 0;
    logic [5:0] rtag = 0;
    string rq;
    for (int w = 3; w >= 0; w--) begin
      if (mst[s*4+w] != 0 && mtag[s*4+w] == tg) hw = w;
      if (mst[s*4+w] == 0) fw = w;
    end
    if (hw >= 0) begin
      v = s*4+hw;
      ex_route = (mst[v] == 3) ? 2 : 1;
      ex_core = mown[v];
      rq = getm ? "R5" : (mst[v] == 3 ? "R4" : "R3");
      if (getm) begin mst[v] = 1; mown[v] = core; end else mst[v] = 3;
    end else begin
      ex_route = 0; ex_core = core; rq = "R2";
      if (fw >= 0) v = s*4+fw;
      else begin
        v = s*4+mrr[s]; mrr[s]++;
        rec = 1; rall = (mst[v] == 3); rcore = mown[v]; rtag = mtag[v];
      end
      mtag[v] = tg; mst[v] = getm ? 1 : 2; mown[v] = core;
    end
    @(negedge clk);
    req_valid = 1; req_getm = getm; req_addr = {tg, s}; req_core = core;
    #1 chk(req_ready === 1'b1, "R8", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1 && rsp_route == 2'(ex_route), rq, rsp_route, ex_route);
    if (ex_route == 1) chk(rsp_core == 2'(ex_core), "R3", rsp_core, ex_core);
    chk(recall_valid === rec, "R7", recall_valid, rec);
    if (rec) begin
      chk(recall_addr == {rtag, s}, "R6", recall_addr, {rtag, s});
      chk(recall_all === rall, "R7", recall_all, rall);
      if (!rall) chk(recall_core == rcore, "R7", recall_core, rcore);
      nack = rall ? NC : 1;
      for (int a = 0; a < nack; a++) begin
        req_valid = 1; req_addr = {tg + 6'd1, s};
        #1 chk(req_ready === 1'b0, "R8", req_ready, 0);
        req_valid = 0; recall_ack = 1;
        @(negedge clk);
        recall_ack = 0;
      end
    end
  endtask

  initial begin
    int x = 11;
    for (int i = 0; i < 16; i++) begin mst[i] = 0; mtag[i] = 0; mown[i] = 0; end
    for (int s = 0; s < 4; s++) mrr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid === 1'b0, "R1", rsp_valid, 0);
    chk(recall_valid === 1'b0, "R1", recall_valid, 0);
    chk(req_ready === 1'b1, "R1", req_ready, 1);
    for (int s = 0; s < 4; s++) do_req(0, 6'd5, 2'(s), 2'(s)); // R1 first touch misses
    for (int n = 0; n < 600; n++) begin
      x = (x * 37 + 13) % 4096;
      do_req(x[11], 6'((x >> 4) % 6), 2'(x >> 2), 2'(x >> 8));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule